// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal and vertical sync, a data-enable strobe and the column/row of the pixel currently being shown. It runs in the pixel clock domain and advances by one pixel on every clock where the pixel clock enable is high, so a faster system clock can drive it with a divided strobe.

Software programs four packed 32-bit timing words (active size, sync widths, horizontal porches, vertical porches) and an output configuration word carrying sync polarities and a 4-bit output format code. Timing words are held in a shadow set and copied into the live set only when the raster wraps from the last pixel of the frame to the first, so a frame is never drawn with mixed timing. At that wrap the block emits a one-clock start-of-frame pulse, which is latched into a status bit; an interrupt line reports that bit when the start-of-frame interrupt is enabled.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted and after release before any enabled clock, hsync and vsync are at their active level (high, polarities reset to 0), de is low, px_x, px_y, out_fmt, sof_pulse and irq are all zero.
- R2: Each line runs sync, back porch, active, front porch; the horizontal lengths in pixels are sync word (address 1) bits 15:0 plus one, horizontal porch word (address 2) bits 31:16 plus one for the back porch, active word (address 0) bits 15:0 plus one, and address 2 bits 15:0 plus one for the front porch. The position advances only on clocks with pix_ce high; hsync is active during the sync span.
- R3: Each frame runs sync, back porch, active, front porch in lines: address 1 bits 31:16 plus one sync lines, address 3 bits 31:16 back-porch lines taken as the true count (zero allowed), address 0 bits 31:16 plus one active lines, address 3 bits 15:0 plus one front-porch lines; vsync is active during the sync lines.
- R4: de is high exactly when both the horizontal and vertical positions are in their active spans; px_x and px_y give the column and row inside the active area and are zero while de is low.
- R5: In the output configuration word (address 4), bit 0 set makes hsync active low and bit 1 set makes vsync active low, effective on the clock after the write.
- R6: Bits 11:8 of the output configuration word appear on out_fmt.
- R7: sof_pulse is high for exactly one clock, the clock after an enabled step from the last pixel of the last line, when the raster shows the first pixel of the first sync line.
- R8: Each start-of-frame event sets a status bit whether or not the interrupt is enabled; irq equals status AND enable. A write to address 5 with bit 0 set enables, a write to address 6 with bit 0 set disables, a write to address 7 with bit 0 set clears the status; writes with bit 0 clear change nothing.
- R9: Timing words written during a frame leave that frame unchanged and apply from the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | 16 | Active column |
| px_y | output | 16 | Active row |
| out_fmt | output | 4 | Output format code |
| sof_pulse | output | 1 | Start-of-frame pulse |
| irq | output | 1 | Start-of-frame interrupt |

## Verification
The hardest situation to provoke is a timing change that lands in the middle of a frame, since the shadow and live sets differ only until the next wrap and the effect is invisible unless the remainder of the old frame is compared pixel by pixel. The bench advances the raster part way, writes a new geometry (including a zero vertical back porch), and keeps a pixel-accurate model that holds the old geometry until its own wrap, comparing every output on every clock with continuous, alternate and irregular pix_ce patterns. The latched status is reached by letting a frame start while the interrupt is disabled and enabling it afterwards.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  localparam int WORD_W = 32;
  localparam int FLD_W  = WORD_W / 2;
  localparam int CNT_W  = FLD_W + 3;
  localparam int ADDR_W = 3;
  localparam int NWORD  = 4;

  // Output configuration word layout
  localparam int HPOL_BIT = 0;
  localparam int VPOL_BIT = 1;
  localparam int FMT_LSB  = 8;
  localparam int FMT_W    = 4;
  // Interrupt control bit position shared by enable/disable/ack writes
  localparam int SOF_BIT  = 0;

  // Shadow word indices equal their write addresses
  localparam int SH_ACT  = 0;
  localparam int SH_SYNC = 1;
  localparam int SH_HP   = 2;
  localparam int SH_VP   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ACTIVE  = 3'd0,
    A_SYNC    = 3'd1,
    A_HPORCH  = 3'd2,
    A_VPORCH  = 3'd3,
    A_OUTCFG  = 3'd4,
    A_IRQ_ON  = 3'd5,
    A_IRQ_OFF = 3'd6,
    A_IRQ_ACK = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [CNT_W-1:0] sync_len;
    logic [CNT_W-1:0] bp_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] fp_len;
  } axis_len_t;

  function automatic logic [CNT_W-1:0] plus1(input logic [FLD_W-1:0] f);
    return CNT_W'(f) + CNT_W'(1);
  endfunction

  function automatic axis_len_t mk_h(input logic [WORD_W-1:0] sync_w,
                                     input logic [WORD_W-1:0] hp_w,
                                     input logic [WORD_W-1:0] act_w);
    axis_len_t l;
    l.sync_len = plus1(sync_w[FLD_W-1:0]);
    l.bp_len   = plus1(hp_w[WORD_W-1:FLD_W]);
    l.act_len  = plus1(act_w[FLD_W-1:0]);
    l.fp_len   = plus1(hp_w[FLD_W-1:0]);
    return l;
  endfunction

  // Vertical back porch is held as its true line count.
  function automatic axis_len_t mk_v(input logic [WORD_W-1:0] sync_w,
                                     input logic [WORD_W-1:0] vp_w,
                                     input logic [WORD_W-1:0] act_w);
    axis_len_t l;
    l.sync_len = plus1(sync_w[WORD_W-1:FLD_W]);
    l.bp_len   = CNT_W'(vp_w[WORD_W-1:FLD_W]);
    l.act_len  = plus1(act_w[WORD_W-1:FLD_W]);
    l.fp_len   = plus1(vp_w[FLD_W-1:0]);
    return l;
  endfunction

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_timing_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_ACT  = 32'h0003_0007,
  parameter logic [WORD_W-1:0] RST_SYNC = 32'h0000_0001,
  parameter logic [WORD_W-1:0] RST_HP   = 32'h0002_0001,
  parameter logic [WORD_W-1:0] RST_VP   = 32'h0002_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         sof_evt,
  output logic [NWORD-1:0][WORD_W-1:0] shadow,
  output logic                         hs_pol,
  output logic                         vs_pol,
  output logic [FMT_W-1:0]             fmt,
  output logic                         irq_en,
  output logic                         irq_stat
);

  localparam int OC_W = FMT_W + 2;

  logic [NWORD-1:0][WORD_W-1:0] shadow_nx;
  logic [OC_W-1:0]              oc_q, oc_nx;
  logic                         en_nx, stat_nx;

  always_comb begin
    shadow_nx = shadow;
    for (int i = 0; i < NWORD; i++) begin
      if (wr_en && (wr_addr == ADDR_W'(i))) shadow_nx[i] = wr_data;
    end

    oc_nx = oc_q;
    if (wr_en && (wr_addr == A_OUTCFG))
      oc_nx = {wr_data[FMT_LSB +: FMT_W], wr_data[VPOL_BIT], wr_data[HPOL_BIT]};

    en_nx = irq_en;
    if (wr_en && (wr_addr == A_IRQ_ON)  && wr_data[SOF_BIT]) en_nx = 1'b1;
    if (wr_en && (wr_addr == A_IRQ_OFF) && wr_data[SOF_BIT]) en_nx = 1'b0;

    stat_nx = irq_stat;
    if (wr_en && (wr_addr == A_IRQ_ACK) && wr_data[SOF_BIT]) stat_nx = 1'b0;
    if (sof_evt) stat_nx = 1'b1;  // a new event wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= {RST_VP, RST_HP, RST_SYNC, RST_ACT};
      oc_q     <= '0;
      irq_en   <= 1'b0;
      irq_stat <= 1'b0;
    end else begin
      shadow   <= shadow_nx;
      oc_q     <= oc_nx;
      irq_en   <= en_nx;
      irq_stat <= stat_nx;
    end
  end

  assign hs_pol = oc_q[0];
  assign vs_pol = oc_q[1];
  assign fmt    = oc_q[OC_W-1:2];

endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr
  import lcd_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  axis_len_t        len,
  output logic             wrap,
  output logic             in_sync,
  output logic             in_act,
  output logic [FLD_W-1:0] pos
);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [CNT_W-1:0] act_start, act_end, total;

  always_comb begin
    act_start = len.sync_len + len.bp_len;
    act_end   = act_start + len.act_len;
    total     = act_end + len.fp_len;
    wrap      = (cnt == total - CNT_W'(1));
    in_sync   = (cnt < len.sync_len);
    in_act    = (cnt >= act_start) && (cnt < act_end);
    pos       = in_act ? FLD_W'(cnt - act_start) : '0;
    cnt_nx    = cnt;
    if (step) cnt_nx = wrap ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_ACT  = 32'h0003_0007,
  parameter logic [WORD_W-1:0] RST_SYNC = 32'h0000_0001,
  parameter logic [WORD_W-1:0] RST_HP   = 32'h0002_0001,
  parameter logic [WORD_W-1:0] RST_VP   = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [FLD_W-1:0]  px_x,
  output logic [FLD_W-1:0]  px_y,
  output logic [FMT_W-1:0]  out_fmt,
  output logic              sof_pulse,
  output logic              irq
);

  localparam int NAX = 2;  // 0: horizontal, 1: vertical

  logic [NWORD-1:0][WORD_W-1:0] shadow, live, live_nx;
  logic                         hs_pol, vs_pol, irq_en, irq_stat;
  logic                         frame_end, sof_q, sof_nx;
  axis_len_t                    len [NAX];
  logic [NAX-1:0]               step, wrap, in_sync, in_act;
  logic [NAX-1:0][FLD_W-1:0]    pos;

  lcd_cfg_regs #(
    .RST_ACT (RST_ACT),
    .RST_SYNC(RST_SYNC),
    .RST_HP  (RST_HP),
    .RST_VP  (RST_VP)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sof_evt (sof_q),
    .shadow  (shadow),
    .hs_pol  (hs_pol),
    .vs_pol  (vs_pol),
    .fmt     (out_fmt),
    .irq_en  (irq_en),
    .irq_stat(irq_stat)
  );

  always_comb begin
    len[0]    = mk_h(live[SH_SYNC], live[SH_HP], live[SH_ACT]);
    len[1]    = mk_v(live[SH_SYNC], live[SH_VP], live[SH_ACT]);
    step[0]   = pix_ce;
    step[1]   = pix_ce & wrap[0];
    frame_end = pix_ce & wrap[0] & wrap[1];
    live_nx   = frame_end ? shadow : live;
    sof_nx    = frame_end;
  end

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    lcd_axis_ctr u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step[g]),
      .len    (len[g]),
      .wrap   (wrap[g]),
      .in_sync(in_sync[g]),
      .in_act (in_act[g]),
      .pos    (pos[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= {RST_VP, RST_HP, RST_SYNC, RST_ACT};
      sof_q <= 1'b0;
    end else begin
      live  <= live_nx;
      sof_q <= sof_nx;
    end
  end

  assign hsync     = in_sync[0] ^ hs_pol;
  assign vsync     = in_sync[1] ^ vs_pol;
  assign de        = in_act[0] & in_act[1];
  assign px_x      = de ? pos[0] : '0;
  assign px_y      = de ? pos[1] : '0;
  assign sof_pulse = sof_q;
  assign irq       = irq_stat & irq_en;

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk
  import lcd_timing_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pix_ce,
  input logic             wr_en,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [FLD_W-1:0] px_x,
  input logic [FLD_W-1:0] px_y,
  input logic             sof_pulse,
  input logic             irq,
  input logic             hs_pol,
  input logic             vs_pol,
  input logic             irq_en
);

  // R4: active video never overlaps horizontal sync
  a_r4_de_outside_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == hs_pol));

  // R4: active video never overlaps vertical sync
  a_r4_de_outside_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (vsync == vs_pol));

  // R7: start-of-frame lasts a single clock
  a_r7_sof_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse);

  // R7: start-of-frame coincides with both syncs active and no video
  a_r7_sof_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> ((hsync != hs_pol) && (vsync != vs_pol) && !de));

  // R2: without a pixel step and without a write the raster outputs hold
  a_r2_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && !wr_en) |=> $stable({hsync, vsync, de, px_x, px_y}));

  // R8: interrupt only while enabled
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_ce   (pix_ce),
  .wr_en    (wr_en),
  .hsync    (hsync),
  .vsync    (vsync),
  .de       (de),
  .px_x     (px_x),
  .px_y     (px_y),
  .sof_pulse(sof_pulse),
  .irq      (irq),
  .hs_pol   (hs_pol),
  .vs_pol   (vs_pol),
  .irq_en   (irq_en)
);

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;

  localparam real CLK_NS = 8.0;
  localparam logic [31:0] W_ACT  = 32'h0003_0007;  // 8 x 4
  localparam logic [31:0] W_SYNC = 32'h0000_0001;  // hs 2, vs 1
  localparam logic [31:0] W_HP   = 32'h0002_0001;  // hbp 3, hfp 2
  localparam logic [31:0] W_VP   = 32'h0002_0000;  // vbp 2, vfp 1

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_ce;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        hsync, vsync, de, sof_pulse, irq;
  logic [15:0] px_x, px_y;
  logic [3:0]  out_fmt;

  always #(CLK_NS / 2.0) clk = ~clk;

  lcd_timing_gen #(
    .RST_ACT(W_ACT), .RST_SYNC(W_SYNC), .RST_HP(W_HP), .RST_VP(W_VP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
    .de(de), .px_x(px_x), .px_y(px_y), .out_fmt(out_fmt),
    .sof_pulse(sof_pulse), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] cur [4];
  logic [31:0] pend [4];
  int bh, bv;
  bit m_hp, m_vp, m_sof;
  int err [4];
  int fa [4];
  int fe [4];
  int fh [4];
  int fv [4];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  function automatic int lo(input logic [31:0] w); return int'(w[15:0]); endfunction
  function automatic int hi(input logic [31:0] w); return int'(w[31:16]); endfunction

  task automatic model_step();
    int htot, vtot;
    htot = (lo(cur[1]) + 1) + (hi(cur[2]) + 1) + (lo(cur[0]) + 1) + (lo(cur[2]) + 1);
    vtot = (hi(cur[1]) + 1) + hi(cur[3]) + (hi(cur[0]) + 1) + (lo(cur[3]) + 1);
    m_sof = 0;
    bh++;
    if (bh == htot) begin
      bh = 0;
      bv++;
      if (bv == vtot) begin
        bv = 0;
        for (int k = 0; k < 4; k++) cur[k] = pend[k];
        m_sof = 1;
      end
    end
  endtask

  task automatic note(input int k, input int a, input int e);
    if (a != e) begin
      if (err[k] == 0) begin fa[k] = a; fe[k] = e; fh[k] = bh; fv[k] = bv; end
      err[k]++;
    end
  endtask

  task automatic compare();
    int hs, hbp, ha, vs, vbp, va, ex, ey;
    bit hact, vact, ede;
    hs = lo(cur[1]) + 1; hbp = hi(cur[2]) + 1; ha = lo(cur[0]) + 1;
    vs = hi(cur[1]) + 1; vbp = hi(cur[3]);     va = hi(cur[0]) + 1;
    hact = (bh >= hs + hbp) && (bh < hs + hbp + ha);
    vact = (bv >= vs + vbp) && (bv < vs + vbp + va);
    ede = hact && vact;
    ex = ede ? bh - (hs + hbp) : 0;
    ey = ede ? bv - (vs + vbp) : 0;
    note(0, int'(hsync), int'((bh < hs) ^ m_hp));
    note(1, int'(vsync), int'((bv < vs) ^ m_vp));
    note(2, int'(de), int'(ede));
    note(2, int'(px_x), ex);
    note(2, int'(px_y), ey);
    note(3, int'(sof_pulse), int'(m_sof));
  endtask

  // Runs n clocks; mode 0: pix_ce always, 1: alternate, 2: two of three.
  task automatic scan(input int n, input int mode, input string label);
    string nm [4];
    nm[0] = "R2 hsync"; nm[1] = "R3 vsync"; nm[2] = "R4 de/px"; nm[3] = "R7 sof";
    for (int k = 0; k < 4; k++) err[k] = 0;
    for (int i = 0; i < n; i++) begin
      bit ce;
      ce = (mode == 0) ? 1'b1 : (mode == 1) ? bit'(i % 2) : bit'((i % 3) != 0);
      pix_ce = ce;
      @(posedge clk);
      if (ce) model_step(); else m_sof = 0;
      @(negedge clk);
      compare();
    end
    for (int k = 0; k < 4; k++) begin
      if (err[k] != 0)
        $display("FAIL %s %s: %0d mismatches, first at h=%0d v=%0d",
                 nm[k], label, err[k], fh[k], fv[k]);
      chk(err[k] == 0, {nm[k], " ", label}, fa[k], fe[k]);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
    pix_ce  = 1'b0;
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    m_sof = 0;
    if (a < 3'd4) pend[a] = d;
    if (a == 3'd4) begin m_hp = d[0]; m_vp = d[1]; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pix_ce = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cur[0] = W_ACT; cur[1] = W_SYNC; cur[2] = W_HP; cur[3] = W_VP;
    for (int k = 0; k < 4; k++) pend[k] = cur[k];
    bh = 0; bv = 0; m_hp = 0; m_vp = 0; m_sof = 0;
    repeat (3) @(negedge clk);
    chk(hsync === 1'b1 && vsync === 1'b1, "R1 syncs active in reset", int'({hsync, vsync}), 3);
    chk(de === 1'b0 && px_x === 16'd0 && px_y === 16'd0, "R1 de/px in reset", int'(de), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sof_pulse === 1'b0 && irq === 1'b0 && out_fmt === 4'd0, "R1 sof/irq/fmt after reset",
        int'({sof_pulse, irq, out_fmt}), 0);
    chk(hsync === 1'b1 && vsync === 1'b1 && de === 1'b0, "R1 origin after release",
        int'({hsync, vsync, de}), 6);
  endtask

  task automatic t_default_scan();
    scan(260, 0, "continuous pix_ce");
    scan(300, 1, "alternate pix_ce");
    scan(330, 2, "irregular pix_ce");
  endtask

  task automatic t_midframe_change();
    scan(47, 0, "R9 before change");
    // new geometry: 5x3 active, hs 3, vs 2, hbp 1, hfp 1, vbp 0, vfp 2
    write_reg(3'd0, 32'h0002_0004);
    write_reg(3'd1, 32'h0001_0002);
    write_reg(3'd2, 32'h0000_0000);
    write_reg(3'd3, 32'h0000_0001);
    scan(260, 0, "R9 change applies at frame start, R3 zero back porch");
  endtask

  task automatic t_polarity_format();
    write_reg(3'd4, 32'h0000_0503);
    chk(out_fmt === 4'd5, "R6 format code", int'(out_fmt), 5);
    scan(150, 0, "R5 both syncs inverted");
    write_reg(3'd4, 32'h0000_0801);
    chk(out_fmt === 4'd8, "R6 format code second value", int'(out_fmt), 8);
    scan(80, 0, "R5 hsync only inverted");
    write_reg(3'd4, 32'h0000_0000);
    chk(out_fmt === 4'd0, "R6 format cleared", int'(out_fmt), 0);
  endtask

  task automatic t_irq();
    write_reg(3'd7, 32'h1);
    write_reg(3'd7, 32'h1);
    write_reg(3'd5, 32'h1);
    chk(irq === 1'b0, "R8 enabled with clear status", int'(irq), 0);
    write_reg(3'd6, 32'h1);
    scan(160, 0, "R8 frame while disabled");
    chk(irq === 1'b0, "R8 no irq while disabled", int'(irq), 0);
    write_reg(3'd5, 32'h1);
    chk(irq === 1'b1, "R8 status latched while disabled", int'(irq), 1);
    write_reg(3'd6, 32'h0);
    chk(irq === 1'b1, "R8 disable write with bit0 clear ignored", int'(irq), 1);
    write_reg(3'd7, 32'h0);
    chk(irq === 1'b1, "R8 ack write with bit0 clear ignored", int'(irq), 1);
    write_reg(3'd6, 32'h1);
    chk(irq === 1'b0, "R8 disable masks", int'(irq), 0);
    write_reg(3'd5, 32'h1);
    chk(irq === 1'b1, "R8 re-enable shows held status", int'(irq), 1);
    write_reg(3'd7, 32'h1);
    chk(irq === 1'b0, "R8 ack clears status", int'(irq), 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default_scan();
    t_midframe_change();
    t_polarity_format();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule